// File: doc/BRIEF.md
# Multiphase Byte Clock Divider

This block divides a single fast oscillator clock (250 MHz, one 4 ns cycle per tick) into the full set of timing waveforms that a byte-serial network station needs. Every waveform is produced as a registered output, decoded from one modulo-20 counter. The set covers a bit-rate clock at half the oscillator rate, a byte load strobe, five phases of a 12.5 MHz byte clock, and a 25 MHz symbol clock. One byte clock phase is also driven out on its own register, to feed an external phase comparator.

The five byte clock phases are spaced either 2 or 4 oscillator cycles apart, chosen by a spacing-select input. In the wide setting they are placed in an interleaved order, so that outputs 1, 3, 5, 2 and 4 fall at successive 16 ns steps. The select input is sampled only at the end of a byte period, so a period is never cut short or stretched part-way through. The symbol clock has a 40/60 duty cycle and falls on every edge of byte clock 1. The load strobe leads byte clock 1 by 3 oscillator cycles (12 ns), so that it switches on a falling edge of the bit clock.

Top module: `byte_clk_divider`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every output is low after that edge, and the counter restarts at phase 0 with narrow spacing selected.
- R2: `bit_clk` is high in the first cycle after reset is released and then toggles on every `clk` cycle (period 2 cycles, high 1 cycle).
- R3: With narrow spacing (spacing select sampled 0), `byte_clk[i]` for i = 0..4 lags `byte_clk[0]` by 2·i cycles.
- R4: With wide spacing (spacing select sampled 1), `byte_clk[2]`, `byte_clk[4]`, `byte_clk[1]` and `byte_clk[3]` lag `byte_clk[0]` by 4, 8, 12 and 16 cycles respectively.
- R5: Each `byte_clk` bit has a period of 20 cycles and is high for 10 consecutive cycles; `byte_clk[0]` rises in the first cycle after reset is released.
- R6: `sym_clk` has a period of 10 cycles, is high for 4 and low for 6, and every falling edge of `sym_clk` coincides with a transition of `byte_clk[0]`.
- R7: `byte_strobe` has a period of 20 cycles with 10 high, changes only in a cycle where `bit_clk` falls, and every edge of it comes 3 cycles before the same-direction edge of `byte_clk[0]`.
- R8: `fb_clk` equals `byte_clk[0]` in every cycle.
- R9: A change on `spacing_sel` takes effect only from the start of the next byte period (the cycle in which `byte_clk[0]` rises); the period in progress keeps its spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one 4 ns cycle per tick |
| rst | input | 1 | Synchronous active-high reset |
| spacing_sel | input | 1 | 0: byte clock phases 2 cycles apart; 1: 4 cycles apart, interleaved order |
| bit_clk | output | 1 | Bit-rate clock, oscillator divided by 2 |
| byte_strobe | output | 1 | Byte load strobe, leads byte clock 1 by 3 cycles |
| byte_clk | output | 5 | Five byte clock phases, bit 0 is byte clock 1 |
| sym_clk | output | 1 | Symbol clock, 40% high, falling with byte clock 1 |
| fb_clk | output | 1 | Copy of byte clock 1 for the external phase comparator |

## Verification
The bench builds the block with its default parameters: a 20-cycle byte period, five phases, steps of 2 and 4 cycles, a 4-cycle symbol high time and a 3-cycle strobe lead. These values match the real station timing, so each cycle of every output can be compared against independently computed offsets. Spacing changes are made in the middle of a byte period, in both directions, to catch a select that leaks in before the wrap. A reset in the middle of a period with wide spacing requested shows that reset returns to narrow spacing until the next wrap.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic {
    SPACE_NARROW = 1'b0,
    SPACE_WIDE   = 1'b1
  } space_e;

  // Position of a lane in the interleaved wide ordering: even lanes fill
  // the early slots, odd lanes follow after them.
  function automatic int wide_slot(input int lane, input int lanes);
    if ((lane % 2) == 0) return lane / 2;
    return (lanes + 1) / 2 + (lane - 1) / 2;
  endfunction

endpackage

// File: rtl/cdiv_count.sv
module cdiv_count #(
  parameter int DIV = 20,
  parameter int CW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cdiv_mode.sv
module cdiv_mode
  import cdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wrap,
  input  logic   spacing_sel,
  output space_e mode
);
  always_ff @(posedge clk) begin
    if (rst)       mode <= SPACE_NARROW;
    else if (wrap) mode <= spacing_sel ? SPACE_WIDE : SPACE_NARROW;
  end
endmodule

// File: rtl/cdiv_lane.sv
module cdiv_lane
  import cdiv_pkg::*;
#(
  parameter int DIV  = 20,
  parameter int CW   = $clog2(DIV),
  parameter int NOFF = 0,
  parameter int WOFF = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  space_e        mode,
  output logic          q
);
  localparam logic [CW:0] NADD = (CW+1)'(DIV - (NOFF % DIV));
  localparam logic [CW:0] WADD = (CW+1)'(DIV - (WOFF % DIV));
  localparam logic [CW:0] MODV = (CW+1)'(DIV);
  localparam logic [CW:0] HALF = (CW+1)'(DIV / 2);

  logic [CW:0] add;
  logic [CW:0] raw;
  logic [CW:0] ph;

  always_comb begin
    add = (mode == SPACE_WIDE) ? WADD : NADD;
    raw = {1'b0, cnt} + add;
    ph  = (raw >= MODV) ? raw - MODV : raw;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (ph < HALF);
  end
endmodule

// File: rtl/cdiv_aux.sv
module cdiv_aux #(
  parameter int DIV         = 20,
  parameter int CW          = $clog2(DIV),
  parameter int SYM_HIGH    = 4,
  parameter int STROBE_LEAD = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  output logic          bit_q,
  output logic          strobe_q,
  output logic          sym_q
);
  localparam logic [CW:0] MODV  = (CW+1)'(DIV);
  localparam logic [CW:0] HALF  = (CW+1)'(DIV / 2);
  localparam logic [CW:0] LEAD  = (CW+1)'(STROBE_LEAD % DIV);
  localparam logic [CW:0] SYMLO = (CW+1)'(DIV / 2 - SYM_HIGH);

  logic [CW:0] sraw;
  logic [CW:0] sph;
  logic [CW:0] yph;

  always_comb begin
    sraw = {1'b0, cnt} + LEAD;
    sph  = (sraw >= MODV) ? sraw - MODV : sraw;
    yph  = ({1'b0, cnt} >= HALF) ? {1'b0, cnt} - HALF : {1'b0, cnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= 1'b0;
      strobe_q <= 1'b0;
      sym_q    <= 1'b0;
    end else begin
      bit_q    <= ~cnt[0];
      strobe_q <= (sph < HALF);
      sym_q    <= (yph >= SYMLO);
    end
  end
endmodule

// File: rtl/byte_clk_divider.sv
module byte_clk_divider
  import cdiv_pkg::*;
#(
  parameter int DIV         = 20,
  parameter int LANES       = 5,
  parameter int NARROW_STEP = 2,
  parameter int WIDE_STEP   = 4,
  parameter int SYM_HIGH    = 4,
  parameter int STROBE_LEAD = 3,
  parameter int FB_LANE     = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spacing_sel,
  output logic             bit_clk,
  output logic             byte_strobe,
  output logic [LANES-1:0] byte_clk,
  output logic             sym_clk,
  output logic             fb_clk
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt;
  logic          wrap;
  space_e        mode;

  cdiv_count #(.DIV(DIV), .CW(CW)) u_count (
    .clk (clk),
    .rst (rst),
    .cnt (cnt),
    .wrap(wrap)
  );

  cdiv_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .wrap       (wrap),
    .spacing_sel(spacing_sel),
    .mode       (mode)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    cdiv_lane #(
      .DIV (DIV),
      .CW  (CW),
      .NOFF(i * NARROW_STEP),
      .WOFF(wide_slot(i, LANES) * WIDE_STEP)
    ) u_lane (
      .clk (clk),
      .rst (rst),
      .cnt (cnt),
      .mode(mode),
      .q   (byte_clk[i])
    );
  end

  // Separate register for the comparator feedback so its load stays off
  // the byte clock nets.
  cdiv_lane #(
    .DIV (DIV),
    .CW  (CW),
    .NOFF(FB_LANE * NARROW_STEP),
    .WOFF(wide_slot(FB_LANE, LANES) * WIDE_STEP)
  ) u_fb (
    .clk (clk),
    .rst (rst),
    .cnt (cnt),
    .mode(mode),
    .q   (fb_clk)
  );

  cdiv_aux #(
    .DIV        (DIV),
    .CW         (CW),
    .SYM_HIGH   (SYM_HIGH),
    .STROBE_LEAD(STROBE_LEAD)
  ) u_aux (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .bit_q   (bit_clk),
    .strobe_q(byte_strobe),
    .sym_q   (sym_clk)
  );
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int LANES   = 5,
  parameter int FB_LANE = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_clk,
  input logic             byte_strobe,
  input logic [LANES-1:0] byte_clk,
  input logic             sym_clk,
  input logic             fb_clk
);
  // live2 is set once both the current and the previous sampled output
  // values were produced after reset release.
  logic live1, live2;
  always_ff @(posedge clk) begin
    if (rst) begin
      live1 <= 1'b0;
      live2 <= 1'b0;
    end else begin
      live1 <= 1'b1;
      live2 <= live1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (!bit_clk && !byte_strobe && byte_clk == '0 && !sym_clk && !fb_clk));

  p_bit_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    live2 |-> (bit_clk != $past(bit_clk)));

  p_sym_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (live2 && $fell(sym_clk)) |-> (byte_clk[0] != $past(byte_clk[0])));

  p_strobe_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (live2 && byte_strobe != $past(byte_strobe)) |-> ($past(bit_clk) && !bit_clk));

  p_strobe_lead_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (live2 && $rose(byte_clk[0])) |-> byte_strobe);

  p_strobe_lead_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (live2 && $fell(byte_clk[0])) |-> !byte_strobe);

  p_fb_match_r8: assert property (@(posedge clk) disable iff (rst)
    live1 |-> (fb_clk == byte_clk[FB_LANE]));
endmodule

bind byte_clk_divider cdiv_checker #(.LANES(LANES), .FB_LANE(FB_LANE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_clk    (bit_clk),
  .byte_strobe(byte_strobe),
  .byte_clk   (byte_clk),
  .sym_clk    (sym_clk),
  .fb_clk     (fb_clk)
);

// File: tb/byte_clk_divider_test.sv
module byte_clk_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spacing_sel = 1'b0;
  logic       bit_clk, byte_strobe, sym_clk, fb_clk;
  logic [4:0] byte_clk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  byte_clk_divider uut (
    .clk(clk), .rst(rst), .spacing_sel(spacing_sel),
    .bit_clk(bit_clk), .byte_strobe(byte_strobe), .byte_clk(byte_clk),
    .sym_clk(sym_clk), .fb_clk(fb_clk)
  );

  typedef struct {
    logic       b, s, y, f;
    logic [4:0] lanes;
    int         ltag;   // 1 reset, 3 narrow, 4 wide, 9 pending change
  } exp_t;

  exp_t q[$];

  int narrow_off[5] = '{0, 2, 4, 6, 8};
  int wide_off[5]   = '{0, 12, 4, 16, 8};

  int mcnt  = 0;
  bit mwide = 0;

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver side: compute the expected outputs after each edge.
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      e = '{b:0, s:0, y:0, f:0, lanes:5'b0, ltag:1};
      mcnt  = 0;
      mwide = 0;
    end else begin
      e.b = (mcnt % 2) == 0;
      e.s = ((mcnt + 3) % 20) < 10;
      e.y = (mcnt % 10) >= 6;
      for (int i = 0; i < 5; i++)
        e.lanes[i] = ((mcnt - (mwide ? wide_off[i] : narrow_off[i]) + 20) % 20) < 10;
      e.f = e.lanes[0];
      e.ltag = (spacing_sel != mwide) ? 9 : (mwide ? 4 : 3);
      if (mcnt == 19) mwide = spacing_sel;
      mcnt = (mcnt + 1) % 20;
    end
    q.push_back(e);
  end

  // Monitor side: compare away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0 && !done) begin
      exp_t e;
      e = q.pop_front();
      if (e.ltag == 1) begin
        chk("R1 outputs", {bit_clk, byte_strobe, sym_clk, fb_clk, 1'b0}, 5'b0);
        chk("R1 byte_clk", byte_clk, 5'b0);
      end else begin
        chk("R2 bit_clk", {4'b0, bit_clk}, {4'b0, e.b});
        chk("R7 byte_strobe", {4'b0, byte_strobe}, {4'b0, e.s});
        chk("R6 sym_clk", {4'b0, sym_clk}, {4'b0, e.y});
        chk("R8 fb_clk", {4'b0, fb_clk}, {4'b0, e.f});
        case (e.ltag)
          3:       chk("R3 byte_clk", byte_clk, e.lanes);
          4:       chk("R4 byte_clk", byte_clk, e.lanes);
          default: chk("R9 byte_clk", byte_clk, e.lanes);
        endcase
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int highs;
    cycles(4);
    rst = 1'b0;
    // R5: first period after reset, byte_clk[0] high for exactly 10 cycles
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (byte_clk[0]) highs++;
    end
    chk("R5 byte_clk[0] high count", 5'(highs), 5'd10);
    cycles(47);
    spacing_sel = 1'b1;    // mid-period change, R9
    cycles(80);
    rst = 1'b1;            // reset mid-run with wide requested, R1
    cycles(3);
    rst = 1'b0;
    cycles(53);
    spacing_sel = 1'b0;    // switch back mid-period
    cycles(60);
    // R5: a wide-mode lane also holds 10 of 20
    spacing_sel = 1'b1;
    cycles(40);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (byte_clk[3]) highs++;
    end
    chk("R5 byte_clk[3] high count", 5'(highs), 5'd10);
    cycles(5);
    finish_run();
  end
endmodule